// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter Pair

This block holds two 16-bit timer/counter units behind a small register file. One 8-bit configuration register sets both units. Each unit picks its own enable rule, its count source and one of four count layouts. A unit counting as a timer advances once per cycle in which the machine-cycle strobe `tick_i` is high. A unit counting as a counter advances on each falling edge of its external count pin. Both the count pins and the gate pins pass through a two-flop synchronizer before the block uses them.

Software reaches the block through one write port and one combinational read port, both addressed by a 3-bit register select. The overflow flags also appear directly on `ovf_o` for an interrupt controller to use. The four layouts are a 13-bit count with a 5-bit prescale in the low byte, a plain 16-bit count, an 8-bit count that reloads from the high byte, and a split layout. In the split layout unit 0 becomes two independent 8-bit counters and unit 1 is frozen.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads zero and `ovf_o` is zero. The register select is 0 = configuration, 1 = control, 2 = unit 0 low byte, 3 = unit 0 high byte, 4 = unit 1 low byte, 5 = unit 1 high byte. Selects 6 and 7 read zero and ignore writes. Configuration bits [7:4] control unit 1 and bits [3:0] control unit 0. Within a nibble, bit 3 is the gate enable, bit 2 is the count source (1 = pin falling edges, 0 = strobe) and bits [1:0] are the layout. Control bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0 and bit 3 is flag 1, and bits [7:4] read zero. Written values read back unchanged.
- R2: Layout 0 counts a 13-bit value {high byte, low[4:0]}. Every increment leaves low[7:5] at zero. An increment at 0x1FFF wraps both bytes to zero and sets the unit's flag.
- R3: Layout 1 counts {high, low} as a 16-bit value. An increment at 0xFFFF wraps to zero and sets the flag.
- R4: Layout 2 increments the low byte. An increment at 0xFF loads the low byte from the high byte and sets the flag. The high byte is never changed by counting.
- R5: With unit 0 in layout 3, its low byte counts under unit 0's run bit, gate and source, and its overflow sets flag 0. Its high byte counts strobes while run 1 is set, and its overflow sets flag 1.
- R6: Unit 1 in layout 3 holds both of its count bytes.
- R7: While unit 0 is in layout 3, unit 1 still counts under its own run bit, but its overflow does not set flag 1.
- R8: With the source bit clear, a unit counts strobe cycles, one per cycle with `tick_i` high. With the source bit set, it counts falling edges of its count pin and ignores `tick_i`. A pin fall driven before clock edge k shows in the count after edge k+2.
- R9: With the gate bit set, a unit counts only while its synchronized gate pin is high and its run bit is set. With the gate bit clear, the run bit alone enables counting.
- R10: A write to a count byte takes priority over counting in that cycle. It cancels that unit's increment and flag set. In layout 3, it cancels only the half being written.
- R11: A flag is set only by an overflow or by a control write. Only a control write clears it, and the flag stays set through later counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Machine-cycle strobe for timer counting |
| cnt_pin_i | input | 2 | External count pins, bit n for unit n |
| gate_pin_i | input | 2 | External gate pins, bit n for unit n |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select for writes |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Register select for reads |
| rd_data_o | output | 8 | Read data, combinational from the selected register |
| ovf_o | output | 2 | Overflow flags, bit n for flag n |

## Verification
A wrong count register appears on the read port in the very next cycle. Because every later increment builds on that value, the error never goes away by itself. A mis-sized wrap or a wrong reload shows up at the first overflow as a wrong low or high byte, together with a flag that is set too early or not at all. Synchronizer or edge-detection faults show up in the pin-count latency, which is checked one edge on either side of the expected cycle. The bench sweeps the timer layouts over start values just below each wrap boundary. It runs enough strobes to cross each boundary, and it compares every byte and flag against an arithmetic model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NU          = 2;   // units in the pair
    localparam int RW          = 8;   // register width
    localparam int AW          = 3;   // register select width
    localparam int PRE         = 5;   // prescale bits of layout 0
    localparam int W13         = RW + PRE;
    localparam int SYNC_STAGES = 2;
    localparam int CNT_BASE    = 2;   // select of unit 0 low byte

    typedef enum logic [AW-1:0] {
        A_MODE = 3'd0,
        A_CTRL = 3'd1,
        A_LO0  = 3'd2,
        A_HI0  = 3'd3,
        A_LO1  = 3'd4,
        A_HI1  = 3'd5,
        A_NA6  = 3'd6,
        A_NA7  = 3'd7
    } addr_e;

    typedef struct packed {
        logic       gate;
        logic       ct;
        logic [1:0] m;
    } cfg_t;

    typedef struct packed {
        logic [RW-1:0] lo;
        logic [RW-1:0] hi;
    } cnt_t;

    typedef struct packed {
        cfg_t [NU-1:0] cfg;
        logic [NU-1:0] run;
        logic [NU-1:0] flag;
        cnt_t [NU-1:0] cnt;
    } st_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2,
    parameter bit EDGE   = 1'b0   // 1: falling-edge pulse, 0: level
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] sig_o
);
    localparam int DEPTH = EDGE ? STAGES + 1 : STAGES;

    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    generate
        if (EDGE) begin : g_edge
            assign sig_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
        end else begin : g_level
            assign sig_o = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tmr_src.sv
module tmr_src import tmr_pkg::*; (
    input  cfg_t cfg_i,
    input  logic run_i,
    input  logic gate_lvl_i,
    input  logic fall_i,
    input  logic tick_i,
    output logic inc_o
);
    logic enable;
    logic source;

    always_comb begin
        enable = run_i & (~cfg_i.gate | gate_lvl_i);
        source = cfg_i.ct ? fall_i : tick_i;
        inc_o  = enable & source;
    end
endmodule

// File: rtl/tmr_step.sv
module tmr_step import tmr_pkg::*; (
    input  logic [1:0] mode_i,
    input  cnt_t       cur_i,
    input  logic       inc_lo_i,
    input  logic       inc_hi_i,
    output cnt_t       nxt_o,
    output logic       ovf_lo_o,
    output logic       ovf_hi_o
);
    logic [W13:0]  s13;
    logic [2*RW:0] s16;
    logic [RW:0]   s8_lo;
    logic [RW:0]   s8_hi;

    always_comb begin
        s13   = {1'b0, cur_i.hi, cur_i.lo[PRE-1:0]} + (W13+1)'(1);
        s16   = {1'b0, cur_i.hi, cur_i.lo} + (2*RW+1)'(1);
        s8_lo = {1'b0, cur_i.lo} + (RW+1)'(1);
        s8_hi = {1'b0, cur_i.hi} + (RW+1)'(1);

        nxt_o    = cur_i;
        ovf_lo_o = 1'b0;
        ovf_hi_o = 1'b0;

        case (mode_i)
            2'd0: if (inc_lo_i) begin
                nxt_o.lo = {{(RW-PRE){1'b0}}, s13[PRE-1:0]};
                nxt_o.hi = s13[W13-1:PRE];
                ovf_lo_o = s13[W13];
            end
            2'd1: if (inc_lo_i) begin
                nxt_o.hi = s16[2*RW-1:RW];
                nxt_o.lo = s16[RW-1:0];
                ovf_lo_o = s16[2*RW];
            end
            2'd2: if (inc_lo_i) begin
                ovf_lo_o = s8_lo[RW];
                nxt_o.lo = s8_lo[RW] ? cur_i.hi : s8_lo[RW-1:0];
            end
            default: begin
                if (inc_lo_i) begin
                    nxt_o.lo = s8_lo[RW-1:0];
                    ovf_lo_o = s8_lo[RW];
                end
                if (inc_hi_i) begin
                    nxt_o.hi = s8_hi[RW-1:0];
                    ovf_hi_o = s8_hi[RW];
                end
            end
        endcase
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair import tmr_pkg::*; (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [NU-1:0] cnt_pin_i,
    input  logic [NU-1:0] gate_pin_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [RW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [RW-1:0] rd_data_o,
    output logic [NU-1:0] ovf_o
);
    st_t           st_q, st_d;
    logic [NU-1:0] gate_lvl, cnt_fall;
    logic [NU-1:0] inc_raw, inc_lo, inc_hi;
    logic [NU-1:0] ovf_lo, ovf_hi;
    logic [NU-1:0] wr_lo, wr_hi;
    cnt_t [NU-1:0] cnt_nx;
    logic          split;

    tmr_sync #(.W(NU), .STAGES(SYNC_STAGES), .EDGE(1'b1)) u_sync_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cnt_pin_i),
        .sig_o (cnt_fall)
    );

    tmr_sync #(.W(NU), .STAGES(SYNC_STAGES), .EDGE(1'b0)) u_sync_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (gate_pin_i),
        .sig_o (gate_lvl)
    );

    assign split = (st_q.cfg[0].m == 2'd3);

    generate
        for (genvar u = 0; u < NU; u++) begin : g_unit
            assign wr_lo[u] = wr_en_i && (wr_addr_i == AW'(CNT_BASE + 2*u));
            assign wr_hi[u] = wr_en_i && (wr_addr_i == AW'(CNT_BASE + 2*u + 1));

            tmr_src u_src (
                .cfg_i      (st_q.cfg[u]),
                .run_i      (st_q.run[u]),
                .gate_lvl_i (gate_lvl[u]),
                .fall_i     (cnt_fall[u]),
                .tick_i     (tick_i),
                .inc_o      (inc_raw[u])
            );

            tmr_step u_step (
                .mode_i   (st_q.cfg[u].m),
                .cur_i    (st_q.cnt[u]),
                .inc_lo_i (inc_lo[u]),
                .inc_hi_i (inc_hi[u]),
                .nxt_o    (cnt_nx[u]),
                .ovf_lo_o (ovf_lo[u]),
                .ovf_hi_o (ovf_hi[u])
            );
        end
    endgenerate

    // Unit 0: a byte write cancels the whole unit, or only the written half when split.
    assign inc_lo[0] = inc_raw[0] & ~wr_lo[0] & (split | ~wr_hi[0]);
    assign inc_hi[0] = split & st_q.run[1] & tick_i & ~wr_hi[0];
    // Unit 1: frozen in its own layout 3.
    assign inc_lo[1] = inc_raw[1] & ~wr_lo[1] & ~wr_hi[1] & (st_q.cfg[1].m != 2'd3);
    assign inc_hi[1] = 1'b0;

    always_comb begin
        st_d = st_q;
        for (int u = 0; u < NU; u++) begin
            st_d.cnt[u] = cnt_nx[u];
        end
        st_d.flag[0] = st_q.flag[0] | ovf_lo[0];
        st_d.flag[1] = st_q.flag[1] | (split ? ovf_hi[0] : (ovf_lo[1] | ovf_hi[1]));

        if (wr_en_i) begin
            case (addr_e'(wr_addr_i))
                A_MODE: st_d.cfg        = wr_data_i;
                A_CTRL: begin
                    st_d.run  = wr_data_i[NU-1:0];
                    st_d.flag = wr_data_i[2*NU-1:NU];
                end
                A_LO0:  st_d.cnt[0].lo = wr_data_i;
                A_HI0:  st_d.cnt[0].hi = wr_data_i;
                A_LO1:  st_d.cnt[1].lo = wr_data_i;
                A_HI1:  st_d.cnt[1].hi = wr_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr_e'(rd_addr_i))
            A_MODE:  rd_data_o = st_q.cfg;
            A_CTRL:  rd_data_o = RW'({st_q.flag, st_q.run});
            A_LO0:   rd_data_o = st_q.cnt[0].lo;
            A_HI0:   rd_data_o = st_q.cnt[0].hi;
            A_LO1:   rd_data_o = st_q.cnt[1].lo;
            A_HI1:   rd_data_o = st_q.cnt[1].hi;
            default: rd_data_o = '0;
        endcase
    end

    assign ovf_o = st_q.flag;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk import tmr_pkg::*; (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic          wr_en_i,
    input logic [AW-1:0] wr_addr_i,
    input logic [NU-1:0] ovf_o,
    input logic [NU-1:0] run_q,
    input cfg_t [NU-1:0] cfg_q,
    input cnt_t [NU-1:0] cnt_q
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en_i && (wr_addr_i == AW'(A_CTRL));

    assert_flag_clear_by_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ovf_o[0]) || $fell(ovf_o[1])) |-> $past(ctrl_wr));

    assert_flag0_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o[0]) |-> $past(run_q[0] || ctrl_wr));

    assert_unit1_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[1].m == 2'd3 && !(wr_en_i && (wr_addr_i == AW'(A_LO1) || wr_addr_i == AW'(A_HI1))))
        |=> $stable(cnt_q[1]));

    assert_reload_keeps_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[0].m == 2'd2 && !(wr_en_i && wr_addr_i == AW'(A_HI0)))
        |=> $stable(cnt_q[0].hi));

    assert_idle_timers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cfg_q[0].ct && !cfg_q[1].ct && !wr_en_i) |=> $stable(cnt_q));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .ovf_o     (ovf_o),
    .run_q     (st_q.run),
    .cfg_q     (st_q.cfg),
    .cnt_q     (st_q.cnt)
);

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] cnt_pin_i = 2'b11;
    logic [1:0] gate_pin_i = 2'b00;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic [1:0] ovf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tmr_pair u_tmr_pair (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .cnt_pin_i(cnt_pin_i), .gate_pin_i(gate_pin_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 8'(d);
        @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_addr_i = 3'(a);
        #1 d = int'(rd_data_o);
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Arithmetic model of one unit in layouts 0..2 after n increments.
    task automatic model(input int m, input int lo, input int hi, input int n,
                         output int elo, output int ehi, output int ef);
        int v, t, rem;
        case (m)
            0: begin
                v = hi * 32 + (lo % 32); t = v + n;
                ef = (t >= 8192) ? 1 : 0; t = t % 8192;
                elo = t % 32; ehi = t / 32;
            end
            1: begin
                v = hi * 256 + lo; t = v + n;
                ef = (t >= 65536) ? 1 : 0; t = t % 65536;
                elo = t % 256; ehi = t / 256;
            end
            default: begin
                ehi = hi;
                if (n <= 255 - lo) begin
                    elo = lo + n; ef = 0;
                end else begin
                    rem = n - (256 - lo);
                    elo = hi + rem % (256 - hi); ef = 1;
                end
            end
        endcase
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int v, elo, ehi, ef;
        int starts_lo [4] = '{8'h00, 8'hE7, 8'hF0, 8'h80};
        int starts_hi [4] = '{8'h00, 8'hFF, 8'hFF, 8'h7F};
        int lens [4] = '{1, 5, 40, 300};

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and register map
        for (int a = 0; a < 8; a++) begin
            rd(a, v); chk("R1 reset read", v, 0);
        end
        chk("R1 reset flags", int'(ovf_o), 0);
        wr(0, 8'hA5); rd(0, v); chk("R1 mode readback", v, 8'hA5);
        wr(1, 8'hFF); rd(1, v); chk("R1 ctrl readback", v, 8'h0F);
        chk("R1 flag pins", int'(ovf_o), 3);
        wr(6, 8'h5A); rd(6, v); chk("R1 unused select", v, 0);
        wr(1, 0); wr(0, 0);

        // R2 R3 R4 R11: sweep of unit 0 timer layouts
        for (int m = 0; m < 3; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int k = 0; k < 4; k++) begin
                    wr(1, 0); wr(0, m);
                    wr(2, starts_lo[s]); wr(3, starts_hi[s]);
                    wr(1, 1);
                    ticks(lens[k]);
                    model(m, starts_lo[s], starts_hi[s], lens[k], elo, ehi, ef);
                    rd(2, v); chk($sformatf("R%0d low m%0d s%0d n%0d", m + 2, m, s, lens[k]), v, elo);
                    rd(3, v); chk($sformatf("R%0d high m%0d s%0d n%0d", m + 2, m, s, lens[k]), v, ehi);
                    rd(1, v); chk($sformatf("R11 flag m%0d s%0d n%0d", m, s, lens[k]), (v >> 2) & 1, ef);
                end
            end
        end

        // R11: flag persists, cleared only by control write
        wr(1, 0); wr(0, 1); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 1);
        ticks(3);
        chk("R11 flag set", int'(ovf_o[0]), 1);
        ticks(10);
        chk("R11 flag held", int'(ovf_o[0]), 1);
        wr(1, 1);
        chk("R11 flag cleared by write", int'(ovf_o[0]), 0);

        // R10: write beats increment in the same cycle
        wr(1, 0); wr(2, 8'hFF); wr(3, 8'hFF); wr(1, 1);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd2; wr_data_i = 8'h10;
        @(posedge clk); @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        rd(2, v); chk("R10 written low kept", v, 8'h10);
        rd(3, v); chk("R10 high not carried", v, 8'hFF);
        chk("R10 no flag", int'(ovf_o[0]), 0);

        // R8: pin counting latency and tick independence (unit 0, layout 1, pin source)
        wr(1, 0); wr(0, 8'h05); wr(2, 0); wr(3, 0); wr(1, 1);
        idle(4);
        cnt_pin_i[0] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(2, v); chk("R8 not yet counted", v, 0);
        @(posedge clk); @(negedge clk);
        rd(2, v); chk("R8 counted after third edge", v, 1);
        tick_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cnt_pin_i[0] = 1'b1; idle(4);
            cnt_pin_i[0] = 1'b0; idle(4);
        end
        tick_i = 1'b0;
        rd(2, v); chk("R8 edge count ignores strobe", v, 7);
        cnt_pin_i[0] = 1'b1;

        // R9: gate on unit 1 (nibble 0x9 = gate, strobe, layout 1)
        wr(1, 0); wr(0, 8'h90); wr(4, 0); wr(5, 0); wr(1, 2);
        gate_pin_i[1] = 1'b0; idle(3);
        ticks(10);
        rd(4, v); chk("R9 gate low blocks", v, 0);
        gate_pin_i[1] = 1'b1; idle(3);
        ticks(10);
        rd(4, v); chk("R9 gate high counts", v, 10);
        wr(1, 0);
        ticks(5);
        rd(4, v); chk("R9 run still required", v, 10);
        gate_pin_i[1] = 1'b0;

        // R5: unit 0 split (0x13: unit 1 layout 1, unit 0 layout 3)
        wr(0, 8'h13); wr(2, 8'hFE); wr(3, 8'hFD); wr(4, 0); wr(5, 0); wr(1, 1);
        ticks(3);
        rd(2, v); chk("R5 low half wraps", v, 8'h01);
        rd(3, v); chk("R5 high half idle without run1", v, 8'hFD);
        chk("R5 flags after low wrap", int'(ovf_o), 1);
        wr(1, 2);
        ticks(4);
        rd(3, v); chk("R5 high half wraps", v, 8'h01);
        rd(2, v); chk("R5 low half idle without run0", v, 8'h01);
        chk("R5 high wrap sets flag1", int'(ovf_o), 2);

        // R7: unit 1 overflow is silent while unit 0 is split
        wr(1, 0); wr(3, 0); wr(4, 8'hFF); wr(5, 8'hFF); wr(1, 2);
        ticks(2);
        rd(4, v); chk("R7 unit1 still counts", v, 1);
        rd(3, v); chk("R7 split high counted", v, 2);
        chk("R7 no flag1", int'(ovf_o[1]), 0);

        // R6: unit 1 frozen in layout 3
        wr(1, 0); wr(0, 8'h30); wr(4, 8'h12); wr(5, 8'h34); wr(1, 2);
        ticks(5);
        rd(4, v); chk("R6 unit1 low held", v, 8'h12);
        rd(5, v); chk("R6 unit1 high held", v, 8'h34);
        chk("R6 no flag1", int'(ovf_o[1]), 0);

        done = 1'b1;
        finish_run();
    end
endmodule